// File: doc/BRIEF.md
# I2C Receive Burst Sequencer

This block clocks a fixed number of data bytes in from an I2C target that has already been addressed. It places them in an on-chip receive queue. A single control write starts a burst. The low seven bits of that write give the byte count, and the top bit asks for a not-acknowledge on the final byte of the burst. The sequencer drives SCL itself, samples SDA, and pulls SDA low in each acknowledge slot. When every counted byte has been stored, it raises a completion flag.

Software reads the bytes one at a time from the head of the queue, and an empty flag shows when nothing is left. Addressing, START, STOP and the splitting of long reads into several bursts are left to software. Setting the final-byte NAK only on the last burst lets software split a long read cleanly across bursts that each fit the queue.

Top module: `i2c_rx_burst`

## Requirements
- R1: A write on `ctrl_we_i` while `busy_o` is low starts a burst. `ctrl_wdata_i[6:0]` is the byte count and `ctrl_wdata_i[7]` is the final-byte NAK flag. Accepting a write clears the completion flag.
- R2: A count field above the queue depth (64) is treated as 64.
- R3: Each byte takes nine SCL clock pulses. The eight data bits are sampled from `sda_i` most significant bit first, on the SCL rising edge.
- R4: During the ninth clock of each byte, `sda_oe_o` is 1 (ACK, SDA pulled low). The exception is the last byte of a burst whose NAK flag is set: there `sda_oe_o` stays 0 (NAK, SDA released).
- R5: `int_stat_o[4]` becomes 1 once the last counted byte is stored. It stays 1 until the next accepted control write. `busy_o` is low whenever it is 1.
- R6: A count of 0 sets `int_stat_o[4]` on the second clock edge after the write and produces no SCL pulse.
- R7: `rd_data_o` shows the oldest stored byte. A pulse on `rd_pop_i` removes it, so bytes leave in the order they arrived.
- R8: `fifo_stat_o[2]` is 1 exactly when the queue holds no byte.
- R9: With the queue empty, `rd_data_o` is 0 and a pulse on `rd_pop_i` changes nothing.
- R10: A control write while `busy_o` is high is ignored, and the running burst keeps its count.
- R11: SCL is held low whenever no burst runs. While a burst runs, each SCL low phase and each high phase lasts `HALF_CYCLES` clocks.
- R12: A byte that arrives while the queue is full is discarded, and the stored bytes are kept unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 8 | Count [6:0], final-byte NAK [7] |
| rd_pop_i | input | 1 | Removes the head byte from the queue |
| rd_data_o | output | 8 | Head byte of the queue, 0 when empty |
| fifo_stat_o | output | 8 | Queue status, bit 2 = empty |
| int_stat_o | output | 8 | Event status, bit 4 = read complete |
| busy_o | output | 1 | A burst is running |
| scl_o | output | 1 | SCL level driven onto the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_oe_o | output | 1 | Pulls SDA low (ACK) when 1 |

## Verification
The bench targets the acknowledge slot of the final byte. A design that ignored the NAK flag, or applied it to every byte, would show the wrong `sda_oe_o` level at the ninth rising edge. Count values of 0 and above 64 are driven directly. Here a missing clamp would clock too many bytes, and a zero count handled as a normal burst would clock the bus or never complete. Further cases are a control write in the middle of a burst, a pop on an empty queue, and a burst that arrives at a full queue. A wrong design would restart the burst, shift the read pointer, or overwrite old data, and each of these shows up as a wrong SCL pulse count or a wrong byte order on draining.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int unsigned CNT_FIELD_W = 7;
  localparam int unsigned NAK_BIT     = 7;
  localparam int unsigned DONE_BIT    = 4;
  localparam int unsigned EMPTY_BIT   = 2;
  localparam int unsigned BITS_PER_B  = 8;
endpackage

// File: rtl/i2c_rx_fifo.sv
module i2c_rx_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned NW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [NW-1:0] cnt_q;
  logic          full, do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == NW'(DEPTH));
  assign do_push = push_i && !full;  // full: drop newcomer
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = empty_o ? '0 : mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + NW'(1);
        2'b01:   cnt_q <= cnt_q - NW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= NW'(DEPTH));
  p_empty_pop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine #(
  parameter int unsigned DEPTH       = 64,
  parameter int unsigned HALF_CYCLES = 4,
  parameter int unsigned CW          = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  input  logic          nak_i,
  input  logic          sda_i,
  output logic          scl_o,
  output logic          sda_oe_o,
  output logic          busy_o,
  output logic          push_o,
  output logic [7:0]    byte_o,
  output logic          done_o
);
  import i2c_rx_pkg::*;
  localparam int unsigned PW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;

  logic [PW-1:0] ph_q;
  logic [3:0]    bit_q;
  logic [CW-1:0] left_q;
  logic [7:0]    shift_q;
  logic          scl_q, busy_q, nak_q, push_q, done_q;
  logic          ph_end, ack_slot;

  assign ph_end   = (ph_q == PW'(HALF_CYCLES - 1));
  assign ack_slot = (bit_q == 4'(BITS_PER_B));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= '0;
      bit_q   <= '0;
      left_q  <= '0;
      shift_q <= '0;
      scl_q   <= 1'b0;
      busy_q  <= 1'b0;
      nak_q   <= 1'b0;
      push_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      push_q <= 1'b0;
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        if (count_i == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          left_q <= count_i;
          nak_q  <= nak_i;
          bit_q  <= '0;
          ph_q   <= '0;
          scl_q  <= 1'b0;
        end
      end else if (busy_q) begin
        if (ph_end) begin
          ph_q  <= '0;
          scl_q <= ~scl_q;
          if (!scl_q) begin
            // rising edge: capture data bit
            if (!ack_slot) shift_q <= {shift_q[6:0], sda_i};
          end else if (ack_slot) begin
            bit_q  <= '0;
            push_q <= 1'b1;
            left_q <= left_q - CW'(1);
            if (left_q == CW'(1)) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end else begin
            bit_q <= bit_q + 4'd1;
          end
        end else begin
          ph_q <= ph_q + PW'(1);
        end
      end
    end
  end

  assign scl_o    = scl_q;
  assign sda_oe_o = busy_q && ack_slot && !(nak_q && left_q == CW'(1));
  assign busy_o   = busy_q;
  assign push_o   = push_q;
  assign byte_o   = shift_q;
  assign done_o   = done_q;

  p_scl_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !scl_q);
  p_count_clamp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= CW'(DEPTH));
  p_ack_ninth_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ack_slot) |-> !sda_oe_o);
endmodule

// File: rtl/i2c_rx_burst.sv
module i2c_rx_burst #(
  parameter int unsigned DEPTH       = 64,
  parameter int unsigned HALF_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_we_i,
  input  logic [7:0] ctrl_wdata_i,
  input  logic       rd_pop_i,
  output logic [7:0] rd_data_o,
  output logic [7:0] fifo_stat_o,
  output logic [7:0] int_stat_o,
  output logic       busy_o,
  output logic       scl_o,
  input  logic       sda_i,
  output logic       sda_oe_o
);
  import i2c_rx_pkg::*;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned FW = (CW > CNT_FIELD_W) ? CW : CNT_FIELD_W;

  logic [FW-1:0] field;
  logic [CW-1:0] count_eff;
  logic          accept, busy, push, done_p, empty, done_q;
  logic [7:0]    rx_byte;

  assign field     = FW'(ctrl_wdata_i[CNT_FIELD_W-1:0]);
  assign count_eff = (field > FW'(DEPTH)) ? CW'(DEPTH) : CW'(field);
  assign accept    = ctrl_we_i && !busy;

  i2c_rx_engine #(.DEPTH(DEPTH), .HALF_CYCLES(HALF_CYCLES), .CW(CW)) u_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .count_i  (count_eff),
    .nak_i    (ctrl_wdata_i[NAK_BIT]),
    .sda_i    (sda_i),
    .scl_o    (scl_o),
    .sda_oe_o (sda_oe_o),
    .busy_o   (busy),
    .push_o   (push),
    .byte_o   (rx_byte),
    .done_o   (done_p)
  );

  i2c_rx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (rx_byte),
    .pop_i   (rd_pop_i),
    .rdata_o (rd_data_o),
    .empty_o (empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     done_q <= 1'b0;
    else if (accept) done_q <= 1'b0;
    else if (done_p) done_q <= 1'b1;
  end

  always_comb begin
    fifo_stat_o            = '0;
    fifo_stat_o[EMPTY_BIT] = empty;
    int_stat_o             = '0;
    int_stat_o[DONE_BIT]   = done_q;
  end
  assign busy_o = busy;

  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy);
  p_busy_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && busy) |=> busy);
endmodule

// File: tb/i2c_rx_burst_tb_top.sv
module i2c_rx_burst_tb_top;
  localparam int DEPTH = 64;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic rd_pop = 1'b0;
  logic [7:0] rd_data, fifo_stat, int_stat;
  logic busy, scl, sda_oe, sda;

  int checks = 0, fails = 0;
  logic [7:0] mem [DEPTH];
  logic [7:0] exp_q [DEPTH];
  bit ack_seen [DEPTH];
  int slv_idx = 0, slv_bit = 0, rises = 0;
  logic scl_prev = 1'b0;

  always #2 clk = ~clk;

  i2c_rx_burst dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .rd_pop_i(rd_pop), .rd_data_o(rd_data), .fifo_stat_o(fifo_stat),
    .int_stat_o(int_stat), .busy_o(busy), .scl_o(scl), .sda_i(sda),
    .sda_oe_o(sda_oe)
  );

  // target model: presents data bits MSB first, releases SDA in the ninth slot
  assign sda = (slv_bit < 8 && slv_idx < DEPTH) ? mem[slv_idx][3'(7 - slv_bit)] : 1'b1;

  always @(negedge clk) begin
    if (ctrl_we && !busy) begin
      slv_idx = 0; slv_bit = 0; rises = 0;
    end else begin
      if (scl && !scl_prev) begin
        rises++;
        if (slv_bit == 8 && slv_idx < DEPTH) ack_seen[slv_idx] = sda_oe;
      end
      if (!scl && scl_prev) begin
        if (slv_bit == 8) begin slv_bit = 0; slv_idx++; end
        else slv_bit++;
      end
    end
    scl_prev = scl;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int eff_count(input int field);
    return (field > DEPTH) ? DEPTH : field;
  endfunction

  function automatic bit exp_ack(input int k, input int n, input bit nak);
    return !(nak && k == n - 1);
  endfunction

  task automatic write_ctrl(input int field, input bit nak);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = {nak, 7'(field)};
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!int_stat[4] && n < LIMIT) begin @(negedge clk); n++; end
  endtask

  task automatic burst(input int field, input bit nak, input bit keep_exp);
    int n, eff;
    eff = eff_count(field);
    for (int k = 0; k < DEPTH; k++) mem[k] = 8'($urandom);
    if (!keep_exp) for (int k = 0; k < DEPTH; k++) exp_q[k] = mem[k];
    write_ctrl(field, nak);
    wait_done(n);
    chk(int_stat[4] == 1'b1, "R5 complete set", int'(int_stat[4]), 1);
    chk(busy == 1'b0, "R5 idle at complete", int'(busy), 0);
    if (eff == 0) chk(n == 1, "R6 zero count timing", n, 1);
    chk(rises == 9 * eff, "R3 R2 scl pulses", rises, 9 * eff);
    chk(scl == 1'b0, "R11 scl low idle", int'(scl), 0);
    for (int k = 0; k < eff; k++)
      if (ack_seen[k] != exp_ack(k, eff, nak))
        chk(1'b0, "R4 ack slot", int'(ack_seen[k]), int'(exp_ack(k, eff, nak)));
    if (eff > 0) chk(ack_seen[eff-1] == exp_ack(eff-1, eff, nak), "R4 last ack",
                     int'(ack_seen[eff-1]), int'(exp_ack(eff-1, eff, nak)));
  endtask

  task automatic drain(input int n);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      if (rd_data != exp_q[k] || fifo_stat[2]) begin
        bad++;
        chk(1'b0, "R7 R8 head byte", int'(rd_data), int'(exp_q[k]));
      end
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
    end
    if (n > 0) chk(bad == 0, "R7 order", bad, 0);
    chk(fifo_stat[2] == 1'b1, "R8 empty after drain", int'(fifo_stat[2]), 1);
    chk(rd_data == 8'h00, "R9 empty data", int'(rd_data), 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl == 1'b0, "R11 reset scl", int'(scl), 0);
    chk(fifo_stat == 8'h04, "R8 reset empty", int'(fifo_stat), 4);
    chk(int_stat == 8'h00, "R5 reset complete", int'(int_stat), 0);
    chk(rd_data == 8'h00 && !sda_oe && !busy, "R9 reset outputs", int'(rd_data), 0);

    // single byte with NAK
    burst(1, 1'b1, 1'b0);
    drain(1);
    // zero count
    burst(0, 1'b0, 1'b0);
    chk(fifo_stat[2] == 1'b1, "R6 nothing stored", int'(fifo_stat[2]), 1);
    // count above depth, ACK on every byte
    burst(100, 1'b0, 1'b0);
    drain(DEPTH);
    // pop on empty queue, then normal burst keeps order
    rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0; @(negedge clk);
    chk(fifo_stat[2] == 1'b1 && rd_data == 8'h00, "R9 empty pop", int'(rd_data), 0);
    burst(2, 1'b1, 1'b0);
    drain(2);

    // write while busy ignored
    for (int k = 0; k < DEPTH; k++) begin mem[k] = 8'($urandom); exp_q[k] = mem[k]; end
    write_ctrl(5, 1'b0);
    chk(int_stat[4] == 1'b0, "R1 complete cleared", int'(int_stat[4]), 0);
    repeat (30) @(negedge clk);
    write_ctrl(10, 1'b1);
    wait_done(n);
    chk(rises == 45, "R10 count kept", rises, 45);
    chk(ack_seen[4] == 1'b1, "R10 nak flag kept", int'(ack_seen[4]), 1);
    drain(5);

    // full queue drops later bytes
    burst(DEPTH, 1'b1, 1'b0);
    chk(fifo_stat[2] == 1'b0, "R8 not empty", int'(fifo_stat[2]), 0);
    burst(3, 1'b0, 1'b1);
    drain(DEPTH);
    chk(fifo_stat[2] == 1'b1, "R12 extra dropped", int'(fifo_stat[2]), 1);

    // random bursts
    for (int i = 0; i < 24; i++) begin
      int f;
      bit nk;
      f  = int'($urandom % 66);
      nk = 1'($urandom);
      burst(f, nk, 1'b0);
      drain(eff_count(f));
    end
    finish_run();
  end
endmodule